// File: doc/BRIEF.md
# Configurable-Latency Pipelined Unsigned Divider

This block divides an unsigned numerator by an unsigned denominator and returns the quotient and the remainder. It is a chain of restoring stages, one per quotient bit, from the most significant bit to the least. Each stage makes one trial subtraction. The chain can be fully combinational, or it can have a chosen number of register levels between stages. A second parameter decides which stage boundaries hold those registers.

The numerator and denominator widths are independent. When the denominator is known never to fall below a power of two, a minimum-denominator-width parameter narrows the quotient and removes the leading stages that could only ever produce zeros. The registers share one clock, one active-low asynchronous clear and one clock enable. A zero denominator gives a defined result, so that case needs no separate flag.

Top module: `pipe_divider`

## Requirements
- R1: For a denominator that is nonzero and at least 2^(DMIN_W-1), `quot_o` is floor(num/den) and `rem_o` is num mod den, so quot×den+rem equals num.
- R2: For such a denominator the remainder is always strictly less than the denominator, at every stage and at the output.
- R3: The quotient width is N_W−DMIN_W+1 and the remainder width is min(N_W, D_W). With DMIN_W>1, results are exact for every denominator of at least 2^(DMIN_W-1).
- R4: With LAT=0 the outputs follow the inputs combinationally. With LAT>0 a result appears after exactly LAT rising clock edges at which `ce_i` is high, and the block accepts a new operand pair on every such edge.
- R5: While `ce_i` is low, every pipeline register keeps its value, so `quot_o` and `rem_o` do not change whatever the inputs do. A result that is in flight completes once `ce_i` returns high.
- R6: A zero denominator gives a quotient of all ones and a remainder equal to the low min(N_W, D_W) bits of the numerator.
- R7: Driving `rst_ni` low clears every pipeline register to zero at once, without waiting for a clock. When the last stage is registered, `quot_o` and `rem_o` then read zero.
- R8: The register position parameter PLACE changes only where the registers sit. PLACE=0 ends the register run at the last stage, PLACE=Q_W−1 starts it at the first stage, and the default Q_W/2 centres it. The results and the latency are the same for every placement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the pipeline registers |
| rst_ni | input | 1 | Active-low asynchronous clear of all pipeline registers |
| ce_i | input | 1 | Clock enable; when low, all registers hold |
| num_i | input | N_W | Unsigned numerator |
| den_i | input | D_W | Unsigned denominator |
| quot_o | output | N_W−DMIN_W+1 | Quotient |
| rem_o | output | min(N_W, D_W) | Remainder |

## Verification
The hardest case to reach from the ports is a clock-enable stall while results are still inside the pipeline. The bench therefore stops the enable one edge after it issues an operand and changes the inputs during the stall. It then checks that the outputs did not move and that the held operand comes out correctly after the remaining enabled edges. Three instances, each swept exhaustively, cover three cases together: a trimmed quotient whose registers sit in mid-chain, a full-width quotient whose registers sit at the end, and a chain with no registers at all.

// File: rtl/div_pkg.sv
package div_pkg;

  function automatic int min_int(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  // first boundary carrying a register; the run is clamped to fit the chain
  function automatic int reg_start(input int q_w, input int lat, input int place);
    int st;
    st = q_w - 1 - place;
    if (st > q_w - lat) st = q_w - lat;
    if (st < 0) st = 0;
    return st;
  endfunction

  function automatic bit stage_reg(input int s, input int q_w, input int lat, input int place);
    int st;
    st = reg_start(q_w, lat, place);
    return (lat > 0) && (s >= st) && (s < st + lat);
  endfunction

endpackage

// File: rtl/div_stage.sv
module div_stage #(
  parameter int D_W = 4,
  parameter int Q_W = 8,
  parameter int BIT = 0
) (
  input  logic [D_W-1:0] pr_i,
  input  logic [Q_W-1:0] qacc_i,
  input  logic           nbit_i,
  input  logic [D_W-1:0] den_i,
  output logic [D_W-1:0] pr_o,
  output logic [Q_W-1:0] qacc_o
);

  logic [D_W:0] trial;

  always_comb begin
    trial  = {pr_i, nbit_i};
    qacc_o = qacc_i;
    if (trial >= {1'b0, den_i}) begin
      pr_o        = trial[D_W-1:0] - den_i;
      qacc_o[BIT] = 1'b1;
    end else begin
      pr_o = trial[D_W-1:0];
    end
    // R2: a bounded partial remainder stays bounded
    if (den_i != '0 && pr_i < den_i)
      p_stage_bound_r2: assert (pr_o < den_i);
  end

endmodule

// File: rtl/div_pipe_reg.sv
module div_pipe_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ce_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (ce_i) q_o <= d_i;
  end

endmodule

// File: rtl/div_result.sv
module div_result #(
  parameter int D_W = 4,
  parameter int Q_W = 8,
  parameter int N_W = 8,
  parameter int R_W = 4
) (
  input  logic           dbz_i,
  input  logic [Q_W-1:0] qacc_i,
  input  logic [D_W-1:0] pr_i,
  input  logic [N_W-1:0] num_i,
  output logic [Q_W-1:0] quot_o,
  output logic [R_W-1:0] rem_o
);

  always_comb begin
    if (dbz_i) begin
      quot_o = '1;
      rem_o  = num_i[R_W-1:0];
    end else begin
      quot_o = qacc_i;
      rem_o  = pr_i[R_W-1:0];
    end
  end

endmodule

// File: rtl/pipe_divider.sv
module pipe_divider #(
  parameter int N_W    = 8,
  parameter int D_W    = 4,
  parameter int DMIN_W = 1,
  parameter int LAT    = 0,
  parameter int PLACE  = (N_W - DMIN_W + 1) / 2,
  localparam int Q_W   = N_W - DMIN_W + 1,
  localparam int R_W   = div_pkg::min_int(N_W, D_W)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ce_i,
  input  logic [N_W-1:0] num_i,
  input  logic [D_W-1:0] den_i,
  output logic [Q_W-1:0] quot_o,
  output logic [R_W-1:0] rem_o
);

  localparam int PR_LO   = 0;
  localparam int QA_LO   = PR_LO + D_W;
  localparam int NM_LO   = QA_LO + Q_W;
  localparam int DN_LO   = NM_LO + N_W;
  localparam int DZ_BIT  = DN_LO + D_W;
  localparam int BUS_W   = DZ_BIT + 1;
  localparam int MIN_DEN = 1 << (DMIN_W - 1);
  localparam int P_W     = N_W + D_W + 1;

  logic [BUS_W-1:0] bus [Q_W+1];
  logic [D_W-1:0]   init_pr;

  // numerator bits above the quotient range seed the partial remainder
  if (Q_W == N_W) begin : g_seed_zero
    assign init_pr = '0;
  end else begin : g_seed_hi
    assign init_pr = D_W'(num_i[N_W-1:Q_W]);
  end

  assign bus[0] = {(den_i == '0), den_i, num_i, {Q_W{1'b0}}, init_pr};

  for (genvar s = 0; s < Q_W; s++) begin : g_stage
    logic [BUS_W-1:0] comb_bus;

    div_stage #(.D_W(D_W), .Q_W(Q_W), .BIT(Q_W - 1 - s)) u_stage (
      .pr_i  (bus[s][PR_LO +: D_W]),
      .qacc_i(bus[s][QA_LO +: Q_W]),
      .nbit_i(bus[s][NM_LO + Q_W - 1 - s]),
      .den_i (bus[s][DN_LO +: D_W]),
      .pr_o  (comb_bus[PR_LO +: D_W]),
      .qacc_o(comb_bus[QA_LO +: Q_W])
    );
    assign comb_bus[BUS_W-1:NM_LO] = bus[s][BUS_W-1:NM_LO];

    if (div_pkg::stage_reg(s, Q_W, LAT, PLACE)) begin : g_reg
      div_pipe_reg #(.W(BUS_W)) u_reg (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .ce_i  (ce_i),
        .d_i   (comb_bus),
        .q_o   (bus[s+1])
      );
    end else begin : g_wire
      assign bus[s+1] = comb_bus;
    end
  end

  logic           dbz_f;
  logic [D_W-1:0] den_f, pr_f;
  logic [N_W-1:0] num_f;
  logic [Q_W-1:0] qacc_f;

  assign dbz_f  = bus[Q_W][DZ_BIT];
  assign den_f  = bus[Q_W][DN_LO +: D_W];
  assign num_f  = bus[Q_W][NM_LO +: N_W];
  assign qacc_f = bus[Q_W][QA_LO +: Q_W];
  assign pr_f   = bus[Q_W][PR_LO +: D_W];

  div_result #(.D_W(D_W), .Q_W(Q_W), .N_W(N_W), .R_W(R_W)) u_result (
    .dbz_i (dbz_f),
    .qacc_i(qacc_f),
    .pr_i  (pr_f),
    .num_i (num_f),
    .quot_o(quot_o),
    .rem_o (rem_o)
  );

  logic [P_W-1:0] recon;
  assign recon = P_W'(qacc_f) * P_W'(den_f) + P_W'(pr_f);

  p_identity_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dbz_f && int'(den_f) >= MIN_DEN) |-> (recon == P_W'(num_f)));

  p_rem_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dbz_f && int'(den_f) >= MIN_DEN) |-> (pr_f < den_f));

  if (LAT > 0) begin : g_hold_chk
    p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ce_i |=> ($stable(quot_o) && $stable(rem_o)));
  end

endmodule

// File: tb/pipe_divider_tb_top.sv
module pipe_divider_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce = 1'b1;
  always #4 clk = ~clk;

  int n_run = 0;
  int n_fail = 0;

  // instance A: full quotient, registers at the end of the chain
  logic [7:0] num_a; logic [3:0] den_a;
  logic [7:0] quot_a; logic [3:0] rem_a;
  pipe_divider #(.N_W(8), .D_W(4), .DMIN_W(1), .LAT(3), .PLACE(0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce),
    .num_i(num_a), .den_i(den_a), .quot_o(quot_a), .rem_o(rem_a));

  // instance B: trimmed quotient, registers centred
  logic [5:0] num_b; logic [5:0] den_b;
  logic [3:0] quot_b; logic [5:0] rem_b;
  pipe_divider #(.N_W(6), .D_W(6), .DMIN_W(3), .LAT(2)) dut_b (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce),
    .num_i(num_b), .den_i(den_b), .quot_o(quot_b), .rem_o(rem_b));

  // instance C: purely combinational
  logic [4:0] num_c; logic [2:0] den_c;
  logic [4:0] quot_c; logic [2:0] rem_c;
  pipe_divider #(.N_W(5), .D_W(3), .DMIN_W(1), .LAT(0)) dut_c (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce),
    .num_i(num_c), .den_i(den_c), .quot_o(quot_c), .rem_o(rem_c));

  task automatic chk(input string tag, input int gq, input int gr, input int eq, input int er);
    n_run++;
    if (gq != eq || gr != er) begin
      n_fail++;
      $display("FAIL %s: got q=%0d r=%0d, expected q=%0d r=%0d", tag, gq, gr, eq, er);
    end
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    summary();
  end

  initial begin
    int sq, sr;
    num_a = '0; den_a = '0; num_b = '0; den_b = '0; num_c = '0; den_c = '0;
    #2;
    // R7: cleared registers read zero at the output of A
    chk("R7 reset", quot_a, rem_a, 0, 0);
    @(negedge clk); rst_n = 1'b1;

    // R1 R6 R4: A streams a new pair every cycle, result LAT=3 cycles later
    for (int k = 0; k < 4096 + 3; k++) begin
      @(negedge clk);
      if (k >= 3) begin
        int idx, n, d;
        idx = k - 3; n = idx >> 4; d = idx & 15;
        if (d == 0) chk("R6 A", quot_a, rem_a, 255, n & 15);
        else begin
          chk("R1 R4 A", quot_a, rem_a, n / d, n % d);
          if (rem_a >= d) chk("R2 A", rem_a, 0, d - 1, 0);
        end
      end
      if (k < 4096) begin num_a = 8'(k >> 4); den_a = 4'(k & 15); end
    end

    // R3 R8: B with trimmed quotient and centred registers, LAT=2
    for (int k = 0; k < 4096 + 2; k++) begin
      @(negedge clk);
      if (k >= 2) begin
        int idx, n, d;
        idx = k - 2; n = idx >> 6; d = idx & 63;
        if (d == 0) chk("R6 B", quot_b, rem_b, 15, n);
        else if (d >= 4) chk("R3 R8 B", quot_b, rem_b, n / d, n % d);
      end
      if (k < 4096) begin num_b = 6'(k >> 6); den_b = 6'(k & 63); end
    end

    // R4: C is combinational, result visible without a clock edge
    for (int k = 0; k < 256; k++) begin
      int n, d;
      @(negedge clk);
      n = k >> 3; d = k & 7;
      num_c = 5'(n); den_c = 3'(d);
      #1;
      if (d == 0) chk("R6 C", quot_c, rem_c, 31, n & 7);
      else chk("R4 C", quot_c, rem_c, n / d, n % d);
    end

    // R5: stall A with one result in flight
    @(negedge clk); num_a = 8'd200; den_a = 4'd7; ce = 1'b1;
    @(negedge clk); ce = 1'b0;
    sq = quot_a; sr = rem_a;
    num_a = 8'd1; den_a = 4'd1;
    repeat (5) @(negedge clk);
    chk("R5 stall hold", quot_a, rem_a, sq, sr);
    ce = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R5 resume", quot_a, rem_a, 28, 4);

    // R7: asynchronous clear between edges
    #1 rst_n = 1'b0;
    #1 chk("R7 async clear", quot_a, rem_a, 0, 0);
    @(negedge clk); rst_n = 1'b1;

    // R6 after clear: A still handles a zero denominator
    num_a = 8'd77; den_a = 4'd0;
    repeat (3) @(negedge clk);
    chk("R6 A post-clear", quot_a, rem_a, 255, 77 & 15);

    summary();
  end

endmodule